// File: doc/BRIEF.md
# DLL Relock Command Gate

This block sits in a DDR SDRAM controller between the command scheduler and the memory command bus. It watches every command that goes out. It decodes writes to the extended mode register and keeps a shadow copy of the three low control bits. Those bits are the DLL disable, the drive-strength select and the optional bus-isolation output enable.

The gate tracks self-refresh entry and exit. Entering self refresh switches the DLL off, and leaving it switches the DLL back on. The gate times two intervals. The lock interval holds reads back until the DLL has had time to lock. The recovery interval holds other commands back after a mode register write or after self-refresh exit. The scheduler uses two qualifiers, read-allowed and non-read-allowed, to decide when it may issue.

The gate does not drop a command that breaks a rule. It records the violation in a sticky error flag. The same flag records illegal programming of the extended register: reserved address bits set, or a write while a bank is busy.

Top module: `dll_relock_gate`

## Requirements
- R1: Command codes are 0 idle, 1 mode register set, 2 read, 3 write, 4 activate, 5 precharge, 6 self-refresh enter, 7 self-refresh exit. A mode register set with bank field 1 (BA1=0, BA0=1) that passes R3 and R4 loads address bits 2..0 into the shadow: bit 0 is DLL disable, bit 1 is drive strength, bit 2 is output-isolation enable. Any other bank value leaves the shadow unchanged.
- R2: After reset the shadow reads 3'b001 (DLL disabled), read-allowed is low, non-read-allowed is high and the error flag is low.
- R3: An extended register write with any of address bits 12..3 nonzero sets the error flag and leaves the shadow unchanged.
- R4: An extended register write while any bit of the bank-idle input is low sets the error flag and leaves the shadow unchanged.
- R5: When a write moves the DLL from disabled to enabled, read-allowed goes high exactly 200 clock edges after the write's edge. A write that keeps the DLL enabled does not restart this wait.
- R6: Any mode register set drops non-read-allowed for one cycle. A non-read command at the second edge after the write is legal.
- R7: In self refresh both qualifiers are low. After exit, non-read-allowed returns so that a command at the 10th edge is legal, and read-allowed returns at the 200th edge.
- R8: While the shadow DLL bit is 1, read-allowed stays low indefinitely, including after self-refresh exit.
- R9: The error flag is set by any of these: a read while read-allowed is low; a non-read command other than self-refresh exit while non-read-allowed is low; a self-refresh exit outside self refresh.
- R10: The error flag is sticky. Only the clear input or reset lowers it, and a new violation in the clear cycle wins.
- R11: The lock timer saturates, so read-allowed stays high for any length of idle time once the DLL is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| cmdValid | input | 1 | A command is issued this cycle |
| cmdCode | input | 3 | Command code (see R1) |
| bankSel | input | 2 | Bank address field of the command |
| addr | input | 13 | Address field of the command |
| bankIdle | input | 4 | Per-bank idle status, 1 = idle |
| errClear | input | 1 | Clears the sticky error flag |
| readOk | output | 1 | A read may be issued |
| nonReadOk | output | 1 | A non-read command may be issued |
| emrShadow | output | 3 | Shadow of extended register bits 2..0 |
| errFlag | output | 1 | Sticky rule-violation flag |

## Verification
Suppose the lock timer were restarted by the wrong event or failed to saturate. Read-allowed would then rise one or more cycles away from the 200th edge, or drop during a long idle stretch. The per-cycle comparison catches either case in the cycle where it happens. A wrong self-refresh state shows within one cycle on both qualifiers. A corrupted shadow shows directly on the shadow port. A wrong violation decode shows on the error flag one edge after the offending command. Because the flag is sticky, a false error stays visible until the next clear.

// File: rtl/dll_gate_pkg.sv
package dll_gate_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_MRS   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_ACT   = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_SRE   = 3'd6,
    CMD_SRX   = 3'd7
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shadowLoad;
    logic lockRestart;
    logic waitLoadMrd;
    logic waitLoadXsnr;
  } gate_strobe_t;

  localparam logic [2:0] SHADOW_RESET = 3'b001;

endpackage

// File: rtl/dll_gate_dp.sv
module dll_gate_dp
  import dll_gate_pkg::*;
#(
  parameter int LOCK_CYCLES = 200,
  parameter int MRD_CYCLES  = 2,
  parameter int XSNR_CYCLES = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  gate_strobe_t strobe,
  input  logic [2:0]   newBits,
  output logic [2:0]   shadowQ,
  output logic         lockDone,
  output logic         waitDone
);

  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam int WAIT_MAX = (MRD_CYCLES > XSNR_CYCLES) ? MRD_CYCLES : XSNR_CYCLES;
  localparam int WAIT_W = $clog2(WAIT_MAX + 1);
  localparam logic [LOCK_W-1:0] LOCK_SAT = '1;
  localparam logic [LOCK_W-1:0] LOCK_TGT = LOCK_W'(LOCK_CYCLES);
  localparam logic [WAIT_W-1:0] MRD_LOAD = WAIT_W'(MRD_CYCLES - 1);
  localparam logic [WAIT_W-1:0] XSNR_LOAD = WAIT_W'(XSNR_CYCLES - 1);

  logic [LOCK_W-1:0] lockCnt;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowQ <= SHADOW_RESET;
    else if (strobe.shadowLoad) shadowQ <= newBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockCnt <= '0;
    else if (strobe.lockRestart) lockCnt <= '0;
    else if (lockCnt != LOCK_SAT) lockCnt <= lockCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (strobe.waitLoadXsnr) waitCnt <= XSNR_LOAD;
    else if (strobe.waitLoadMrd) waitCnt <= MRD_LOAD;
    else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
  end

  assign lockDone = (lockCnt >= LOCK_TGT);
  assign waitDone = (waitCnt == '0);

  p_shadow_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shadowLoad |=> $stable(shadowQ));
  p_lock_saturate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (lockCnt == LOCK_SAT) && !strobe.lockRestart |=> lockCnt == LOCK_SAT);
  p_mrd_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.waitLoadMrd && !strobe.waitLoadXsnr |=> !waitDone);
  p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockRestart |=> !lockDone);

endmodule

// File: rtl/dll_gate_ctrl.sv
module dll_gate_ctrl
  import dll_gate_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic                 addrHiNz,
  input  logic                 newDllOff,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic                 errClear,
  input  logic                 dllOff,
  input  logic                 lockDone,
  input  logic                 waitDone,
  output gate_strobe_t         strobe,
  output logic                 readOk,
  output logic                 nonReadOk,
  output logic                 errFlag
);

  localparam logic [BANK_W-1:0] EMR_BANK = BANK_W'(1);

  cmd_e cmd;
  logic inSr;
  logic isMrs, isEmr, emrBad, isRead, isSre, isSrx, isNonRead, errSet;

  assign cmd       = cmd_e'(cmdCode);
  assign isMrs     = cmdValid && (cmd == CMD_MRS);
  assign isEmr     = isMrs && (bankSel == EMR_BANK);
  assign emrBad    = isEmr && (addrHiNz || !(&bankIdle));
  assign isRead    = cmdValid && (cmd == CMD_READ);
  assign isSre     = cmdValid && (cmd == CMD_SRE);
  assign isSrx     = cmdValid && (cmd == CMD_SRX);
  assign isNonRead = cmdValid && (cmd != CMD_IDLE) && (cmd != CMD_READ) && (cmd != CMD_SRX);

  assign readOk    = !dllOff && !inSr && lockDone;
  assign nonReadOk = !inSr && waitDone;

  always_comb begin
    strobe.shadowLoad   = isEmr && !emrBad;
    strobe.lockRestart  = (isEmr && !emrBad && dllOff && !newDllOff) || (isSrx && inSr);
    strobe.waitLoadMrd  = isMrs;
    strobe.waitLoadXsnr = isSrx && inSr;
  end

  assign errSet = emrBad || (isRead && !readOk) || (isNonRead && !nonReadOk)
                || (isSrx && !inSr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inSr <= 1'b0;
    else if (isSre) inSr <= 1'b1;
    else if (isSrx) inSr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (errSet) errFlag <= 1'b1;
    else if (errClear) errFlag <= 1'b0;
  end

  p_sr_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    inSr |-> !readOk && !nonReadOk);
  p_dll_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    dllOff |-> !readOk);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClear |=> errFlag);
  p_reserved_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    isEmr && addrHiNz |=> errFlag);
  p_bad_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    isRead && !readOk |=> errFlag);

endmodule

// File: rtl/dll_relock_gate.sv
module dll_relock_gate
  import dll_gate_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int NUM_BANKS   = 4,
  parameter int LOCK_CYCLES = 200,
  parameter int MRD_CYCLES  = 2,
  parameter int XSNR_CYCLES = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic                 errClear,
  output logic                 readOk,
  output logic                 nonReadOk,
  output logic [2:0]           emrShadow,
  output logic                 errFlag
);

  gate_strobe_t strobe;
  logic lockDone, waitDone;

  dll_gate_ctrl #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .bankSel(bankSel), .addrHiNz(|addr[ADDR_W-1:3]), .newDllOff(addr[0]),
    .bankIdle(bankIdle), .errClear(errClear), .dllOff(emrShadow[0]),
    .lockDone(lockDone), .waitDone(waitDone), .strobe(strobe),
    .readOk(readOk), .nonReadOk(nonReadOk), .errFlag(errFlag)
  );

  dll_gate_dp #(.LOCK_CYCLES(LOCK_CYCLES), .MRD_CYCLES(MRD_CYCLES),
                .XSNR_CYCLES(XSNR_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newBits(addr[2:0]),
    .shadowQ(emrShadow), .lockDone(lockDone), .waitDone(waitDone)
  );

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 3'd1 && bankSel == BANK_W'(1) && !(&bankIdle)
    |=> $stable(emrShadow) && errFlag);

endmodule

// File: tb/tb_dll_relock_gate.sv
`timescale 1ns/1ps
module tb_dll_relock_gate;

  localparam logic [2:0] C_IDLE = 3'd0, C_MRS = 3'd1, C_READ = 3'd2,
                         C_ACT = 3'd4, C_SRE = 3'd6, C_SRX = 3'd7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdCode = C_IDLE;
  logic [1:0] bankSel = 2'd0;
  logic [12:0] addr = '0;
  logic [3:0] bankIdle = 4'hF;
  logic errClear = 1'b0;
  logic readOk, nonReadOk, errFlag;
  logic [2:0] emrShadow;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [2:0] mShadow;
  bit mInSr, mErr;
  int mAge, mWait;

  always #4 clk = ~clk;

  dll_relock_gate dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .bankSel(bankSel), .addr(addr), .bankIdle(bankIdle), .errClear(errClear),
    .readOk(readOk), .nonReadOk(nonReadOk), .emrShadow(emrShadow), .errFlag(errFlag)
  );

  function automatic bit mRead();
    return !mShadow[0] && !mInSr && (mAge >= 200);
  endfunction
  function automatic bit mNonRead();
    return !mInSr && (mWait == 0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mShadow = 3'b001; mInSr = 0; mAge = 0; mWait = 0; mErr = 0;
    end else begin
      bit setE, emr, bad, rd, nrd;
      setE = 0;
      emr = cmdValid && cmdCode == C_MRS && bankSel == 2'd1;
      bad = emr && ((addr[12:3] != 0) || (bankIdle != 4'hF));
      rd = mRead(); nrd = mNonRead();
      if (bad) setE = 1;
      if (cmdValid && cmdCode == C_READ && !rd) setE = 1;
      if (cmdValid && cmdCode != C_IDLE && cmdCode != C_READ && cmdCode != C_SRX && !nrd) setE = 1;
      if (cmdValid && cmdCode == C_SRX && !mInSr) setE = 1;
      mAge = mAge + 1;
      if (mWait > 0) mWait = mWait - 1;
      if (cmdValid && cmdCode == C_MRS) mWait = 1;
      if (emr && !bad) begin
        if (mShadow[0] && !addr[0]) mAge = 0;
        mShadow = addr[2:0];
      end
      if (cmdValid && cmdCode == C_SRE) mInSr = 1;
      else if (cmdValid && cmdCode == C_SRX && mInSr) begin
        mInSr = 0; mWait = 9; mAge = 0;
      end
      if (setE) mErr = 1;
      else if (errClear) mErr = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("R1 model shadow", emrShadow, mShadow);
      check("R5 model readOk", readOk, mRead());
      check("R6 model nonReadOk", nonReadOk, mNonRead());
      check("R9 model errFlag", errFlag, mErr);
    end
  end

  task automatic drive(logic [2:0] c, logic [1:0] b, logic [12:0] a);
    cmdValid = (c != C_IDLE); cmdCode = c; bankSel = b; addr = a;
    @(negedge clk);
    cmdValid = 0; cmdCode = C_IDLE; bankSel = 0; addr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearErr();
    errClear = 1;
    @(negedge clk);
    errClear = 0;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset shadow", emrShadow, 1);
    check("R2 reset readOk", readOk, 0);
    check("R2 reset nonReadOk", nonReadOk, 1);
    check("R2 reset errFlag", errFlag, 0);
    rstN = 1;
    idle(2);

    drive(C_READ, 0, 0);
    check("R9 read before lock", errFlag, 1);
    clearErr();
    check("R10 clear", errFlag, 0);

    drive(C_MRS, 2'd0, 13'h6);
    check("R1 base register ignored", emrShadow, 1);
    check("R6 block after mrs", nonReadOk, 0);
    idle(1);
    check("R6 release after mrs", nonReadOk, 1);

    drive(C_MRS, 2'd1, 13'h6);
    check("R1 shadow load", emrShadow, 6);
    idle(1);
    drive(C_ACT, 0, 0);
    check("R6 act at second edge legal", errFlag, 0);
    idle(197);
    check("R5 read blocked at 199", readOk, 0);
    idle(1);
    check("R5 read open at 200", readOk, 1);
    drive(C_READ, 0, 0);
    check("R5 read legal", errFlag, 0);

    bankIdle = 4'b1011;
    drive(C_MRS, 2'd1, 13'h0);
    bankIdle = 4'hF;
    check("R4 busy error", errFlag, 1);
    check("R4 busy shadow kept", emrShadow, 6);
    clearErr(); idle(2);

    drive(C_MRS, 2'd1, 13'h20);
    check("R3 reserved error", errFlag, 1);
    check("R3 reserved shadow kept", emrShadow, 6);
    clearErr(); idle(2);

    drive(C_MRS, 2'd1, 13'h0);
    check("R5 no restart when enabled", readOk, 1);
    idle(2);
    drive(C_MRS, 2'd3, 13'h1);
    check("R1 other bank ignored", emrShadow, 0);
    idle(300);
    check("R11 saturated readOk", readOk, 1);
    drive(C_READ, 0, 0);
    check("R11 late read legal", errFlag, 0);

    drive(C_SRE, 0, 0);
    check("R7 sr blocks read", readOk, 0);
    check("R7 sr blocks nonread", nonReadOk, 0);
    drive(C_ACT, 0, 0);
    check("R9 act in sr", errFlag, 1);
    clearErr();
    drive(C_SRX, 0, 0);
    check("R7 exit blocks nonread", nonReadOk, 0);
    idle(8);
    check("R7 nonread blocked edge 8", nonReadOk, 0);
    idle(1);
    check("R7 nonread open edge 9", nonReadOk, 1);
    idle(190);
    check("R7 read blocked 199", readOk, 0);
    idle(1);
    check("R7 read open 200", readOk, 1);

    drive(C_SRX, 0, 0);
    check("R9 exit outside sr", errFlag, 1);
    clearErr();

    drive(C_MRS, 2'd1, 13'h1);
    check("R8 dll off blocks read", readOk, 0);
    idle(2);
    drive(C_SRE, 0, 0);
    drive(C_SRX, 0, 0);
    idle(250);
    check("R8 still blocked after sr", readOk, 0);
    check("R8 nonread open", nonReadOk, 1);

    errClear = 1;
    drive(C_READ, 0, 0);
    errClear = 0;
    check("R10 set wins over clear", errFlag, 1);
    idle(5);
    check("R10 sticky", errFlag, 1);
    clearErr();
    check("R10 cleared", errFlag, 0);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule